// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupt

This block is the digital back end of an analog voltage comparator. It takes the raw comparator decision, which may change at any time. It resynchronizes that decision and can filter it, so that a change is accepted only after it has held for a chosen number of sampling cycles. The filter can also be switched off. The filter samples on every system clock, or only on cycles where a peripheral-rate enable pulse is high. The conditioned result can be driven to a dedicated output pin. Its transitions in one chosen direction set a sticky interrupt flag.

Software reaches the block through a simple word-wide register port. A control word holds the comparator enable, the input-channel code and the reference-level code. It also holds the edge direction, the pin enable, the filter length and the sampling source. Separate words hold the interrupt enable, the read-only flag and a write-only clear. The channel code, the reference code and a reference-generator enable are driven out to the analog macro and to the pin multiplexer, which sit outside this block.

Top module: `cmp_cond_top`

## Requirements
- R1: After reset every control field, the interrupt enable and the flag are 0. Offset 0x00 reads 0x0000_1000, offsets 0x10 and 0x14 read 0, and `irq` is 0.
- R2: The raw input passes through two flops. With filter code 3 (bypass), `cmp_pin_out` follows a change of `cmp_raw` 2 clock edges later.
- R3: Filter code 0, 1 or 2 accepts a change only after the new value has been sampled on 1, 2 or 3 sampling cycles in a row. When every clock samples, the output changes 3, 4 or 5 edges after `cmp_raw` changes. With code 2, a pulse shorter than 3 samples is dropped.
- R4: With control bit 11 at 1 the filter samples on every clock. With bit 11 at 0 it samples only on cycles where `pclk_tick` is high, and the output holds while `pclk_tick` stays low.
- R5: While the enable (control bit 31) is 0, the status bit (control bit 12) reads 1 and `cmp_pin_out` is 1.
- R6: Control bit 7 picks the edge. With 0, a rising conditioned output sets the flag (offset 0x14 bit 0); with 1, a falling one does. An edge in the other direction does not set it. The flag stays set until it is cleared.
- R7: No edge is reported on the first cycle after the enable goes to 1, even if the output changes value at enable.
- R8: Writing 1 to bit 0 of offset 0x18 clears the flag. Writing 0 there leaves it unchanged.
- R9: If an edge and a clear come in the same cycle, the flag ends up set.
- R10: `irq` equals the flag ANDed with bit 0 of offset 0x10.
- R11: `chan_sel` gives control bits [4:0] while enabled and 0 otherwise. `chan_ok` is 1 only when the block is enabled and the code is below 24.
- R12: `ref_sel` gives control bits [6:5] and `ref_on` is the enable. `cmp_pin_oe` gives control bit 8.
- R13: Writes to offset 0x00 ignore bits 30:12. Writes to offset 0x14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_tick | input | 1 | Peripheral-rate sample enable, synchronous to clk |
| cmp_raw | input | 1 | Raw comparator decision, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| chan_sel | output | 5 | Negative-input channel code |
| chan_ok | output | 1 | Channel code is valid and the comparator is enabled |
| ref_sel | output | 2 | Reference level code |
| ref_on | output | 1 | Reference generator enable |
| cmp_pin_oe | output | 1 | Route the conditioned output to its pin |
| cmp_pin_out | output | 1 | Conditioned comparator output |
| irq | output | 1 | Interrupt request |

## Verification
A wrong filter count or a stuck synchronizer shows up as `cmp_pin_out` changing one or more edges earlier or later than the fixed latency for that code. A pulse that should be dropped would instead show up as a change on the output. The check is exact to the edge. A wrong edge history or a wrong arming state sets the flag when it should not, at enable or on the edge in the other direction. That flag can be read at offset 0x14 within three cycles of the change. A wrong clear priority shows up at once as a flag of 0 after the colliding cycle.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_IE   = 'h10;
  localparam int unsigned OFS_FLAG = 'h14;
  localparam int unsigned OFS_CLR  = 'h18;
  localparam int unsigned CHAN_W   = 5;
  localparam int unsigned CHAN_NUM = 24;
  localparam int unsigned DB_W     = 2;
  localparam logic [DB_W-1:0] DB_BYPASS = '1;

  typedef struct packed {
    logic              en;
    logic              clk_sel;
    logic [DB_W-1:0]   db;
    logic              oe;
    logic              dir;
    logic [1:0]        ref_sel;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  generate
    if (STAGES == 1) begin : g_one
      assign st_d = din;
    end else begin : g_many
      assign st_d = {st_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/cmp_debounce.sv
module cmp_debounce
  import cmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            smp_en,
  input  logic [DB_W-1:0] db,
  input  logic            din,
  output logic            dout
);
  localparam int unsigned CNT_W = DB_W;

  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             bypass;

  assign bypass  = (db == DB_BYPASS);
  assign limit   = CNT_W'(db) + CNT_W'(1);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!en) begin
      filt_d = 1'b1;
      cnt_d  = '0;
    end else if (bypass) begin
      filt_d = din;
      cnt_d  = '0;
    end else if (din == filt_q) begin
      cnt_d = '0;
    end else if (smp_en) begin
      if (cnt_inc >= limit) begin
        filt_d = din;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout = !en ? 1'b1 : (bypass ? din : filt_q);

  // R4: without a sample enable the filtered value is held
  a_r4_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en && !bypass && !smp_en) && en) |-> $stable(filt_q));
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic              ie,
  output logic              clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam int unsigned LOW_W = $bits(ctrl_t) - 1;
  localparam int unsigned PAD_W = DATA_W - 2 - LOW_W;

  ctrl_t ctrl_q, ctrl_d;
  logic  ie_q, ie_d;
  logic  unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-2:LOW_W];

  always_comb begin
    ctrl_d = ctrl_q;
    ie_d   = ie_q;
    if (wr && addr == A_CTRL) ctrl_d = {wdata[DATA_W-1], wdata[LOW_W-1:0]};
    if (wr && addr == A_IE)   ie_d   = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ie_q   <= ie_d;
    end
  end

  assign clr = wr && (addr == A_CLR) && wdata[0];

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)      rdata = {ctrl_q.en, {PAD_W{1'b0}}, status, ctrl_q[LOW_W-1:0]};
    else if (addr == A_IE)   rdata = {{(DATA_W-1){1'b0}}, ie_q};
    else if (addr == A_FLAG) rdata = {{(DATA_W-1){1'b0}}, flag};
  end

  assign ctrl = ctrl_q;
  assign ie   = ie_q;

  // R13: a write to another offset leaves the control word unchanged
  a_r13_ctrl_only_by_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic status,
  input  logic dir,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic armed_q, prev_q, flag_q, flag_d;
  logic hit;

  assign hit = armed_q && en &&
               (dir ? (prev_q && !status) : (!prev_q && status));

  always_comb begin
    flag_d = flag_q;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= en;
      prev_q  <= status;
      flag_q  <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q && ie;

  // R8: a clear with no edge empties the flag
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);
  // R9: an edge sets the flag even with a clear in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R6: the flag is sticky
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R7: nothing is reported before the edge history is armed
  a_r7_no_edge_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !flag_q) |=> !flag_q);
endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
  import cmp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_tick,
  input  logic              cmp_raw,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              chan_ok,
  output logic [1:0]        ref_sel,
  output logic              ref_on,
  output logic              cmp_pin_oe,
  output logic              cmp_pin_out,
  output logic              irq
);
  ctrl_t ctrl;
  logic  ie, clr, flag, status, raw_s, smp_en;

  assign smp_en = ctrl.clk_sel || pclk_tick;

  cmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .status(status), .flag(flag), .ctrl(ctrl), .ie(ie), .clr(clr), .rdata(bus_rdata)
  );

  cmp_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cmp_raw), .dout(raw_s)
  );

  cmp_debounce u_db (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .smp_en(smp_en), .db(ctrl.db),
    .din(raw_s), .dout(status)
  );

  cmp_edge_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .status(status), .dir(ctrl.dir),
    .clr(clr), .ie(ie), .flag(flag), .irq(irq)
  );

  assign chan_sel    = ctrl.en ? ctrl.chan : '0;
  assign chan_ok     = ctrl.en && (ctrl.chan < CHAN_W'(CHAN_NUM));
  assign ref_sel     = ctrl.ref_sel;
  assign ref_on      = ctrl.en;
  assign cmp_pin_oe  = ctrl.oe;
  assign cmp_pin_out = status;

  // R5: a disabled comparator presents 1
  a_r5_disabled_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> status);
endmodule

// File: tb/tb_cmp_cond_top.sv
`timescale 1ns/1ps
module tb_cmp_cond_top;
  logic        clk = 1'b0;
  logic        rst_n, pclk_tick, cmp_raw, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [4:0]  chan_sel;
  logic [1:0]  ref_sel;
  logic        chan_ok, ref_on, cmp_pin_oe, cmp_pin_out, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_cond_top dut (
    .clk(clk), .rst_n(rst_n), .pclk_tick(pclk_tick), .cmp_raw(cmp_raw),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_sel(chan_sel), .chan_ok(chan_ok), .ref_sel(ref_sel), .ref_on(ref_on),
    .cmp_pin_oe(cmp_pin_oe), .cmp_pin_out(cmp_pin_out), .irq(irq)
  );

  // control word: en=bit31 clk_sel=bit11 db=bits10:9 oe=bit8 dir=bit7 ref=bits6:5 chan=bits4:0
  localparam logic [31:0] BASE = 32'h8000_0945; // en, every-clock sampling, oe, ref 2, chan 5
  // vector: {db code, edges from raw change to output change}
  localparam logic [5:0] VEC [4] = '{{2'd3, 4'd2}, {2'd0, 4'd3}, {2'd1, 4'd4}, {2'd2, 4'd5}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #0.1; d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; pclk_tick = 0; cmp_raw = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    cyc(5); rst_n = 1; cyc(2);

    rd(5'h00, v); chk(v == 32'h0000_1000, "R1 ctrl reset", v, 32'h1000);
    rd(5'h10, v); chk(v == 0, "R1 ie reset", v, 0);
    rd(5'h14, v); chk(v == 0, "R1 flag reset", v, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);
    chk(cmp_pin_out == 1, "R5 disabled pin", cmp_pin_out, 1);

    wr(5'h00, 32'h0000_0005);
    chk(chan_sel == 0 && !chan_ok, "R11 chan gated off", {chan_ok, chan_sel}, 0);

    // enable with falling-edge select and bypass; output goes 1->0 at enable
    wr(5'h00, BASE | 32'h80 | (32'd3 << 9));
    cyc(6);
    rd(5'h14, v); chk(v == 0, "R7 no edge at enable", v, 0);
    chk(chan_sel == 5 && chan_ok, "R11 chan on", {chan_ok, chan_sel}, 32'h25);
    chk(ref_sel == 2 && ref_on && cmp_pin_oe, "R12 ref and pin enable", {ref_on, cmp_pin_oe, ref_sel}, 32'hE);

    wr(5'h00, BASE | 32'h80 | (32'd3 << 9) | 32'h4010_1000);
    rd(5'h00, v); chk(v == (BASE | 32'h80 | (32'd3 << 9)), "R13 ignored bits", v, BASE | 32'h80 | (32'd3 << 9));
    wr(5'h14, 32'h1);
    rd(5'h14, v); chk(v == 0, "R13 flag read-only", v, 0);

    foreach (VEC[i]) begin
      wr(5'h00, BASE | (32'(VEC[i][5:4]) << 9));
      cyc(8);
      wr(5'h18, 32'h1);
      cmp_raw = 1;
      cyc(int'(VEC[i][3:0]) - 1);
      chk(cmp_pin_out == 0, "R2/R3 before latency", cmp_pin_out, 0);
      cyc(1);
      chk(cmp_pin_out == 1, "R2/R3 at latency", cmp_pin_out, 1);
      cyc(3);
      rd(5'h14, v); chk(v == 1, "R6 rising sets flag", v, 1);
      cmp_raw = 0; cyc(8);
      rd(5'h14, v); chk(v == 1, "R6 flag sticky", v, 1);
    end

    chk(irq == 0, "R10 irq masked", irq, 0);
    wr(5'h10, 32'h1);
    chk(irq == 1, "R10 irq enabled", irq, 1);
    wr(5'h18, 32'h0);
    rd(5'h14, v); chk(v == 1, "R8 clear with 0", v, 1);
    wr(5'h18, 32'h1);
    rd(5'h14, v); chk(v == 0 && irq == 0, "R8 clear with 1", {irq, v[0]}, 0);

    wr(5'h00, BASE | 32'h80 | (32'd3 << 9));
    cmp_raw = 1; cyc(6);
    rd(5'h14, v); chk(v == 0, "R6 rising ignored when falling selected", v, 0);
    cmp_raw = 0; cyc(6);
    rd(5'h14, v); chk(v == 1, "R6 falling sets flag", v, 1);

    cmp_raw = 1; cyc(6);
    cmp_raw = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(5'h18, 32'h1);
    rd(5'h14, v); chk(v == 1, "R9 set wins over clear", v, 1);

    wr(5'h18, 32'h1);
    wr(5'h00, BASE | (32'd2 << 9));
    cyc(8);
    cmp_raw = 1; cyc(2); cmp_raw = 0;
    cyc(10);
    chk(cmp_pin_out == 0, "R3 short pulse dropped", cmp_pin_out, 0);
    rd(5'h14, v); chk(v == 0, "R3 no flag from pulse", v, 0);

    wr(5'h00, (BASE & ~32'h800) | (32'd0 << 9));
    cmp_raw = 1; cyc(10);
    chk(cmp_pin_out == 0, "R4 held without tick", cmp_pin_out, 0);
    pclk_tick = 1; cyc(1); pclk_tick = 0;
    chk(cmp_pin_out == 1, "R4 tick samples", cmp_pin_out, 1);

    cmp_raw = 0; cyc(10);
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk(v == 32'h0000_1000 && cmp_pin_out, "R5 disabled reads 1", v, 32'h1000);
    chk(!ref_on && chan_sel == 0, "R12 ref off when disabled", {ref_on, chan_sel}, 0);

    wr(5'h00, 32'h8000_001A);
    chk(chan_sel == 26 && !chan_ok, "R11 invalid channel", {chan_ok, chan_sel}, 32'h1A);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule